// File: doc/BRIEF.md
# Programmable-Depth Video FIFO with Sticky Overrun

This block buffers parallel video words arriving behind the input latches and lets the depth be chosen while running. A small depth field picks between zero and four storage stages. At zero stages the block is a single register stage, so the data path keeps a constant one-cycle latency and no words are held. At one to four stages it is a first-in first-out buffer: the consumer sees the oldest word whenever the buffer is not empty, and pops it with a read enable.

The block drives empty and full status flags and a sticky overrun flag. Overrun records that a producer tried to push into a full buffer. It stays set until the host pulses a status-read strobe. While either of the two dynamic-flush enables is high, overrun is held off. Any change of the depth field empties the buffer, so the occupancy can never exceed the new depth.

Top module: `vfifo_prog`

## Requirements
- R1: `depth_sel` is read as an unsigned binary stage count. Values 0 to 4 select that many stages, and values 5 to 7 behave as 4.
- R2: With depth 0, `dout_vld` and `dout` show the `wr_vld` and `wr_data` of the previous cycle. `rd_en` has no effect, `empty` reads 1, `full` reads 0, and overrun never sets.
- R3: With depth N from 1 to 4, up to N words are held and `full` is 1 exactly when N words are held. `empty` is 1 exactly when none are held, `dout_vld` equals not-empty, `dout` is the oldest word, and `rd_en` while not empty removes it, so words leave in write order.
- R4: A write while full and without `rd_en` is dropped and the stored words are unchanged. A write while full with `rd_en` in the same cycle is accepted.
- R5: A dropped write to a full buffer sets `overrun` from the next cycle on.
- R6: `overrun` stays set until a cycle with `stat_rd` high, and reads 0 from the cycle after that strobe.
- R7: If `stat_rd` and a new dropped write fall in the same cycle, `overrun` stays 1.
- R8: While `flush_fifo_dyn` or `flush_msg_dyn` is 1, `overrun` reads 0 from the next cycle and is not set by dropped writes.
- R9: A cycle in which the clamped `depth_sel` differs from the depth in use empties the buffer. A write in that cycle is dropped, and the new depth applies from the next cycle.
- R10: Synchronous active-high `rst` leaves the buffer empty, `overrun` at 0 and `dout_vld` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| depth_sel | input | 3 | Requested stage count |
| wr_vld | input | 1 | Write strobe for `wr_data` |
| wr_data | input | W | Video word in |
| rd_en | input | 1 | Pop the oldest word |
| dout | output | W | Oldest word, or the bypass register at depth 0 |
| dout_vld | output | 1 | `dout` is valid |
| flush_fifo_dyn | input | 1 | Dynamic video flush enable; holds off overrun |
| flush_msg_dyn | input | 1 | Dynamic message flush enable; holds off overrun |
| stat_rd | input | 1 | Host read of the overrun status; clears it |
| empty | output | 1 | No word held |
| full | output | 1 | Held words equal the depth |
| overrun | output | 1 | Sticky dropped-write flag |

## Verification
The colliding pair is the host's clearing status read and a fresh dropped write to a full buffer. The bench fills a one-stage buffer, sets overrun, and then raises `stat_rd` in the very cycle a further write hits the full buffer. The flag must still read 1 afterwards, and only a later lone read clears it. A second pairing, a pop and a push on a full buffer in one cycle, is judged by no overrun and the correct word order.

// File: rtl/vfifo_pkg.sv
package vfifo_pkg;

    typedef enum logic {
        PATH_BYPASS = 1'b0,
        PATH_BUFFER = 1'b1
    } path_e;

endpackage

// File: rtl/vf_depth_ctl.sv
module vf_depth_ctl #(
    parameter int SELW = 3,
    parameter int MAXD = 4,
    localparam int CW  = $clog2(MAXD + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [SELW-1:0] depth_sel,
    output logic [CW-1:0]   depth_cur,
    output logic            change
);

    typedef struct packed {
        logic [CW-1:0] depth;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [CW-1:0] eff;

    always_comb begin
        if (32'(depth_sel) > MAXD) begin
            eff = CW'(MAXD);
        end else begin
            eff = CW'(depth_sel);
        end
        ctl_d       = ctl_q;
        ctl_d.depth = eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.depth <= eff;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign depth_cur = ctl_q.depth;
    assign change    = (eff != ctl_q.depth);

    // R1: the stage count in use never exceeds the largest depth
    p_depth_max_r1: assert property (@(posedge clk) disable iff (rst)
        32'(depth_cur) <= MAXD);

endmodule

// File: rtl/vf_store.sv
module vf_store #(
    parameter int W    = 10,
    parameter int MAXD = 4,
    localparam int CW  = $clog2(MAXD + 1),
    localparam int PW  = (MAXD > 1) ? $clog2(MAXD) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);

    typedef struct packed {
        logic [MAXD-1:0][W-1:0] mem;
        logic [PW-1:0]          wptr;
        logic [PW-1:0]          rptr;
        logic [CW-1:0]          cnt;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        if (32'(p) == MAXD - 1) begin
            return '0;
        end
        return p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.wptr = '0;
            st_d.rptr = '0;
            st_d.cnt  = '0;
        end else begin
            if (push) begin
                st_d.mem[st_q.wptr] = wdata;
                st_d.wptr           = step(st_q.wptr);
            end
            if (pop) begin
                st_d.rptr = step(st_q.rptr);
            end
            case ({push, pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = st_q.mem[st_q.rptr];
    assign count = st_q.cnt;

    // R3: never pop from an empty store
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0));

    // R4: a push into a full store only happens together with a pop
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        (push && (32'(count) == MAXD)) |-> pop);

endmodule

// File: rtl/vf_ovr_flag.sv
module vf_ovr_flag (
    input  logic clk,
    input  logic rst,
    input  logic attempt,
    input  logic clear_rd,
    input  logic suppress,
    output logic flag
);

    typedef struct packed {
        logic set;
    } ovr_t;

    ovr_t ovr_d, ovr_q;

    always_comb begin
        ovr_d = ovr_q;
        if (suppress) begin
            ovr_d.set = 1'b0;
        end else if (attempt) begin
            ovr_d.set = 1'b1;
        end else if (clear_rd) begin
            ovr_d.set = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_q <= '0;
        end else begin
            ovr_q <= ovr_d;
        end
    end

    assign flag = ovr_q.set;

    // R5: a dropped write raises the flag
    p_ovr_set_r5: assert property (@(posedge clk) disable iff (rst)
        (attempt && !suppress) |=> flag);

    // R6: the flag holds until a status read
    p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (flag && !clear_rd && !suppress) |=> flag);

    // R7: a read colliding with a new event leaves the flag set
    p_ovr_collide_r7: assert property (@(posedge clk) disable iff (rst)
        (attempt && clear_rd && !suppress) |=> flag);

    // R8: suppression keeps the flag low
    p_ovr_off_r8: assert property (@(posedge clk) disable iff (rst)
        suppress |=> !flag);

endmodule

// File: rtl/vfifo_prog.sv
module vfifo_prog #(
    parameter int W    = 10,
    parameter int SELW = 3,
    parameter int MAXD = 4,
    localparam int CW  = $clog2(MAXD + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [SELW-1:0] depth_sel,
    input  logic            wr_vld,
    input  logic [W-1:0]    wr_data,
    input  logic            rd_en,
    output logic [W-1:0]    dout,
    output logic            dout_vld,
    input  logic            flush_fifo_dyn,
    input  logic            flush_msg_dyn,
    input  logic            stat_rd,
    output logic            empty,
    output logic            full,
    output logic            overrun
);

    import vfifo_pkg::*;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] data;
    } byp_t;

    logic [CW-1:0] depth_cur;
    logic          change;
    logic [CW-1:0] count;
    logic [W-1:0]  head;
    path_e         path;
    logic          buf_full;
    logic          buf_empty;
    logic          push;
    logic          pop;
    logic          attempt;
    logic          suppress;
    byp_t          byp_d, byp_q;

    vf_depth_ctl #(.SELW(SELW), .MAXD(MAXD)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .depth_sel (depth_sel),
        .depth_cur (depth_cur),
        .change    (change)
    );

    always_comb begin
        path      = (depth_cur == '0) ? PATH_BYPASS : PATH_BUFFER;
        buf_empty = (count == '0);
        buf_full  = (path == PATH_BUFFER) && (count == depth_cur);
        pop       = (path == PATH_BUFFER) && !change && rd_en && !buf_empty;
        push      = (path == PATH_BUFFER) && !change && wr_vld && (!buf_full || pop);
        attempt   = !change && wr_vld && buf_full && !rd_en;
        suppress  = flush_fifo_dyn || flush_msg_dyn;
    end

    vf_store #(.W(W), .MAXD(MAXD)) u_store (
        .clk   (clk),
        .rst   (rst),
        .flush (change),
        .push  (push),
        .pop   (pop),
        .wdata (wr_data),
        .head  (head),
        .count (count)
    );

    vf_ovr_flag u_ovr (
        .clk      (clk),
        .rst      (rst),
        .attempt  (attempt),
        .clear_rd (stat_rd),
        .suppress (suppress),
        .flag     (overrun)
    );

    always_comb begin
        byp_d = byp_q;
        if (path == PATH_BYPASS && !change) begin
            byp_d.vld  = wr_vld;
            byp_d.data = wr_data;
        end else begin
            byp_d.vld  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            byp_q <= '0;
        end else begin
            byp_q <= byp_d;
        end
    end

    always_comb begin
        if (path == PATH_BYPASS) begin
            dout     = byp_q.data;
            dout_vld = byp_q.vld;
            empty    = 1'b1;
            full     = 1'b0;
        end else begin
            dout     = head;
            dout_vld = !buf_empty;
            empty    = buf_empty;
            full     = buf_full;
        end
    end

    // R3: occupancy bounded by the depth in use
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        !change |-> (count <= depth_cur));

    // R2: bypass forwards the previous cycle's strobe
    p_bypass_r2: assert property (@(posedge clk) disable iff (rst)
        (depth_cur == '0 && !change) |=> (dout_vld == $past(wr_vld)));

    // R9: a depth change leaves the buffer empty
    p_flush_r9: assert property (@(posedge clk) disable iff (rst)
        change |=> (count == '0));

endmodule

// File: tb/vfifo_prog_bench.sv
module vfifo_prog_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] depth_sel;
    logic       wr_vld;
    logic [9:0] wr_data;
    logic       rd_en;
    logic [9:0] dout;
    logic       dout_vld;
    logic       fa, fb, sr;
    logic       empty, full, overrun;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    vfifo_prog u_vfifo_prog (
        .clk            (clk),
        .rst            (rst),
        .depth_sel      (depth_sel),
        .wr_vld         (wr_vld),
        .wr_data        (wr_data),
        .rd_en          (rd_en),
        .dout           (dout),
        .dout_vld       (dout_vld),
        .flush_fifo_dyn (fa),
        .flush_msg_dyn  (fb),
        .stat_rd        (sr),
        .empty          (empty),
        .full           (full),
        .overrun        (overrun)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_depth(input logic [2:0] d);
        depth_sel = d; wr_vld = 0; rd_en = 0;
        tick();
    endtask

    task automatic fill(input int n, input logic [9:0] base);
        for (int i = 0; i < n; i++) begin
            wr_vld = 1; wr_data = base + 10'(i);
            tick();
        end
        wr_vld = 0;
    endtask

    task automatic drain(input int n, input logic [9:0] base, input string tag);
        rd_en = 1;
        for (int i = 0; i < n; i++) begin
            check({tag, " vld"}, 32'(dout_vld), 1);
            check({tag, " data"}, 32'(dout), 32'(base + 10'(i)));
            tick();
        end
        rd_en = 0;
        check({tag, " empty after drain"}, 32'(empty), 1);
    endtask

    task automatic status_read();
        sr = 1; tick(); sr = 0;
    endtask

    task automatic t_reset();
        rst = 1; depth_sel = 0; wr_vld = 0; wr_data = 0; rd_en = 0;
        fa = 0; fb = 0; sr = 0;
        tick(); tick();
        rst = 0;
        check("R10 empty", 32'(empty), 1);
        check("R10 overrun", 32'(overrun), 0);
        check("R10 dout_vld", 32'(dout_vld), 0);
    endtask

    task automatic t_bypass();
        set_depth(0);
        rd_en = 1;
        wr_vld = 1; wr_data = 10'h155; tick();
        check("R2 vld", 32'(dout_vld), 1);
        check("R2 data", 32'(dout), 32'h155);
        check("R2 empty", 32'(empty), 1);
        check("R2 full", 32'(full), 0);
        wr_data = 10'h2aa; tick();
        check("R2 data2", 32'(dout), 32'h2aa);
        wr_vld = 0; tick();
        check("R2 vld low", 32'(dout_vld), 0);
        rd_en = 0;
        wr_vld = 1;
        for (int i = 0; i < 6; i++) tick();
        wr_vld = 0;
        check("R2 no overrun", 32'(overrun), 0);
    endtask

    task automatic t_depth(input int n);
        logic [9:0] base = 10'(16 * n);
        set_depth(3'(n));
        check("R3 empty at start", 32'(empty), 1);
        fill(n - 1, base);
        check("R3 not full below depth", 32'(full), 0);
        fill(1, base + 10'(n - 1));
        check("R3 full at depth", 32'(full), 1);
        check("R3 not empty", 32'(empty), 0);
        wr_vld = 1; wr_data = 10'h3ff; tick(); wr_vld = 0;
        check("R5 overrun set", 32'(overrun), 1);
        tick(); tick();
        check("R6 overrun sticky", 32'(overrun), 1);
        drain(n, base, "R4 order after drop");
        status_read();
        check("R6 overrun cleared", 32'(overrun), 0);
    endtask

    task automatic t_clamp();
        set_depth(3'd7);
        fill(3, 10'h070);
        check("R1 depth7 not full at 3", 32'(full), 0);
        fill(1, 10'h073);
        check("R1 depth7 full at 4", 32'(full), 1);
        set_depth(3'd5);
        check("R1 5 vs 7 same depth kept", 32'(full), 1);
        drain(4, 10'h070, "R1 clamp drain");
    endtask

    task automatic t_push_pop_full();
        set_depth(2);
        fill(2, 10'h0a0);
        wr_vld = 1; rd_en = 1; wr_data = 10'h0a2; tick();
        wr_vld = 0; rd_en = 0;
        check("R4 push+pop no overrun", 32'(overrun), 0);
        check("R4 push+pop full", 32'(full), 1);
        drain(2, 10'h0a1, "R4 push+pop order");
    endtask

    task automatic t_collide();
        set_depth(1);
        fill(1, 10'h011);
        wr_vld = 1; wr_data = 10'h012; tick();
        check("R5 set depth1", 32'(overrun), 1);
        sr = 1; tick(); sr = 0; wr_vld = 0;
        check("R7 read+event stays set", 32'(overrun), 1);
        status_read();
        check("R7 lone read clears", 32'(overrun), 0);
        drain(1, 10'h011, "R7 contents");
    endtask

    task automatic t_suppress();
        set_depth(2);
        fill(2, 10'h050);
        fa = 1; wr_vld = 1; wr_data = 10'h0ff; tick(); wr_vld = 0;
        check("R8 fifo flush blocks set", 32'(overrun), 0);
        fa = 0;
        wr_vld = 1; tick(); wr_vld = 0;
        check("R8 set after release", 32'(overrun), 1);
        fb = 1; tick();
        check("R8 msg flush clears", 32'(overrun), 0);
        fb = 0; tick();
        check("R8 stays low after release", 32'(overrun), 0);
        drain(2, 10'h050, "R8 contents");
    endtask

    task automatic t_change();
        set_depth(3);
        fill(2, 10'h030);
        depth_sel = 2; wr_vld = 1; wr_data = 10'h1ee; tick(); wr_vld = 0;
        check("R9 emptied", 32'(empty), 1);
        check("R9 no vld", 32'(dout_vld), 0);
        fill(2, 10'h040);
        check("R9 new depth full", 32'(full), 1);
        drain(2, 10'h040, "R9 new contents");
    endtask

    initial begin
        t_reset();
        t_bypass();
        for (int n = 1; n <= 4; n++) t_depth(n);
        t_clamp();
        t_push_pop_full();
        t_collide();
        t_suppress();
        t_change();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule